// File: doc/BRIEF.md
# Mixed-Decay and Holding-Torque Controller

This block chooses, for each motor winding of a stepper current chopper, whether the off-time of the PWM cycle uses fast decay or slow decay. On every step event it reads a per-winding flag that tells whether that winding's current target falls on the step. In the two mixed modes it starts a per-winding timer that keeps fast decay selected for a programmed number of clock cycles before slow decay takes over. Two fixed modes force fast or slow decay on all windings at all times.

A second timer tracks how long the motor has been still. When the programmed idle time has passed since the last step, the current reference select moves from the normal level to the lower holding level. It stays there until the next step. A zero idle delay disables this switch. All delays are clock counts held in registers. Both outputs are registered.

Top module: `decay_hold_ctrl`

## Requirements
- R1: With `mode` = 2'b00 (fixed fast), every bit of `fast_sel` is 1 from the cycle after that mode is sampled, whether or not steps occur.
- R2: With `mode` = 2'b01 (fixed slow), every bit of `fast_sel` is 0 from the cycle after that mode is sampled.
- R3: With `mode` = 2'b10 (single-mixed), a winding whose `dec_flags` bit is 1 at a step edge has `fast_sel` high for exactly `dly_down` cycles counted from that edge, then low. A winding whose bit is 0 (rising or unchanged target) stays low.
- R4: With `mode` = 2'b11 (dual-mixed), a winding with `dec_flags` bit 1 is fast for `dly_down` cycles and one with bit 0 is fast for `dly_up` cycles after the step edge, each then slow.
- R5: A fast-decay duration of 0 gives no fast interval for the winding that would use it.
- R6: A step event reloads every winding timer from that step's flags and delays, cutting short any interval still running.
- R7: With `dly_hold` = H > 0, `ref_hold` goes high H cycles after the last step edge and stays high while no step arrives.
- R8: `ref_hold` is low in the cycle after any step edge.
- R9: While `dly_hold` is 0, `ref_hold` is low from the next cycle on, even if it was high.
- R10: After reset, `fast_sel` is all zeros and `ref_hold` is 0 until a step and a timeout occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Decay mode: 00 fast, 01 slow, 10 single-mixed, 11 dual-mixed |
| step_evt | input | 1 | One-cycle strobe marking a step |
| dec_flags | input | NUM_WIND | Bit i is 1 when winding i's current target falls on this step |
| dly_down | input | DLY_W | Fast-decay duration for a falling winding, in cycles |
| dly_up | input | DLY_W | Fast-decay duration for a rising winding (dual-mixed), in cycles |
| dly_hold | input | DLY_W | Idle time before the holding reference is selected; 0 disables |
| fast_sel | output | NUM_WIND | Bit i high selects fast decay for winding i |
| ref_hold | output | 1 | High selects the holding current reference |

## Verification
The hardest state to reach is a step arriving while an earlier fast interval and the idle count are both still running, since the outcome depends on the reload winning over the countdown in the same edge. The bench issues back-to-back steps a few cycles apart with swapped direction flags so a winding that was counting fast is reloaded with a zero duration. It also lets the holding reference engage and then clears the idle delay with no step, to show the disable acting on a state already held.

// File: rtl/dk_pkg.sv
package dk_pkg;
  typedef enum logic [1:0] {
    DK_FAST = 2'b00,
    DK_SLOW = 2'b01,
    DK_MIX1 = 2'b10,
    DK_MIX2 = 2'b11
  } dk_mode_e;
endpackage

// File: rtl/dk_win_timer.sv
module dk_win_timer
  import dk_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  dk_mode_e         mode,
  input  logic             dec,
  input  logic [DLY_W-1:0] dly_dn,
  input  logic [DLY_W-1:0] dly_up,
  output logic             fast_q
);
  logic [DLY_W-1:0] cnt_q, cnt_d, load_val;

  always_comb begin
    case (mode)
      DK_MIX1: load_val = dec ? dly_dn : '0;
      DK_MIX2: load_val = dec ? dly_dn : dly_up;
      default: load_val = '0;
    endcase
    if (step)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      case (mode)
        DK_FAST: fast_q <= 1'b1;
        DK_SLOW: fast_q <= 1'b0;
        default: fast_q <= (cnt_d != '0);
      endcase
    end
  end
endmodule

// File: rtl/dk_hold_timer.sv
module dk_hold_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [DLY_W-1:0] dly,
  output logic             hold_q
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (step) begin
      cnt_q  <= dly;
      hold_q <= 1'b0;
    end else if (dly == '0) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (cnt_q == DLY_W'(1)) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/decay_hold_ctrl.sv
module decay_hold_ctrl
  import dk_pkg::*;
#(
  parameter int NUM_WIND = 2,
  parameter int DLY_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  input  logic                step_evt,
  input  logic [NUM_WIND-1:0] dec_flags,
  input  logic [DLY_W-1:0]    dly_down,
  input  logic [DLY_W-1:0]    dly_up,
  input  logic [DLY_W-1:0]    dly_hold,
  output logic [NUM_WIND-1:0] fast_sel,
  output logic                ref_hold
);
  dk_mode_e mode_e;
  assign mode_e = dk_mode_e'(mode);

  for (genvar w = 0; w < NUM_WIND; w++) begin : g_win
    dk_win_timer #(.DLY_W(DLY_W)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .step   (step_evt),
      .mode   (mode_e),
      .dec    (dec_flags[w]),
      .dly_dn (dly_down),
      .dly_up (dly_up),
      .fast_q (fast_sel[w])
    );
  end

  dk_hold_timer #(.DLY_W(DLY_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .step   (step_evt),
    .dly    (dly_hold),
    .hold_q (ref_hold)
  );
endmodule

// File: rtl/dk_chk.sv
module dk_chk #(
  parameter int NUM_WIND = 2,
  parameter int DLY_W    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          mode,
  input logic                step_evt,
  input logic [NUM_WIND-1:0] dec_flags,
  input logic [DLY_W-1:0]    dly_hold,
  input logic [NUM_WIND-1:0] fast_sel,
  input logic                ref_hold
);
  logic seen_clk;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  p_fast_mode_r1: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && !$past(rst) && $past(mode) == 2'b00) |-> (fast_sel == '1));

  p_slow_mode_r2: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && !$past(rst) && $past(mode) == 2'b01) |-> (fast_sel == '0));

  p_single_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && !$past(rst) && $past(step_evt) && $past(mode) == 2'b10)
      |-> ((fast_sel & ~$past(dec_flags)) == '0));

  p_step_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && !$past(rst) && $past(step_evt)) |-> !ref_hold);

  p_hold_off_r9: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && !$past(rst) && $past(dly_hold) == '0) |-> !ref_hold);

  p_hold_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && !$past(rst) && $rose(ref_hold)) |-> !$past(step_evt));
endmodule

bind decay_hold_ctrl dk_chk #(.NUM_WIND(NUM_WIND), .DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .step_evt  (step_evt),
  .dec_flags (dec_flags),
  .dly_hold  (dly_hold),
  .fast_sel  (fast_sel),
  .ref_hold  (ref_hold)
);

// File: tb/sim_decay_hold_ctrl.sv
module sim_decay_hold_ctrl;
  localparam int NW = 2;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b01;
  logic          step_evt = 1'b0;
  logic [NW-1:0] dec_flags = '0;
  logic [W-1:0]  dly_down = '0, dly_up = '0, dly_hold = '0;
  logic [NW-1:0] fast_sel;
  logic          ref_hold;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  decay_hold_ctrl #(.NUM_WIND(NW), .DLY_W(W)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .step_evt(step_evt),
    .dec_flags(dec_flags), .dly_down(dly_down), .dly_up(dly_up),
    .dly_hold(dly_hold), .fast_sel(fast_sel), .ref_hold(ref_hold)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Issue one step and check `cyc` cycles after it. t counts cycles from the step edge.
  task automatic run_step(int md, int dec, int dn, int up, int hd, int cyc, string ovr);
    @(negedge clk);
    mode = 2'(md); dec_flags = NW'(dec);
    dly_down = W'(dn); dly_up = W'(up); dly_hold = W'(hd);
    step_evt = 1'b1;
    @(posedge clk);
    for (int t = 0; t < cyc; t++) begin
      @(negedge clk);
      step_evt = 1'b0;
      for (int w = 0; w < NW; w++) begin
        int dur, e;
        string tg;
        bit dw;
        dw = dec[w];
        case (md)
          0: begin e = 1; tg = "R1"; end
          1: begin e = 0; tg = "R2"; end
          2: begin dur = dw ? dn : 0;  e = (t < dur); tg = (dw && dn == 0) ? "R5" : "R3"; end
          default: begin dur = dw ? dn : up; e = (t < dur); tg = (dur == 0) ? "R5" : "R4"; end
        endcase
        if (ovr != "") tg = ovr;
        check(tg, int'(fast_sel[w]), e);
      end
      begin
        int eh;
        string th;
        eh = (hd != 0 && t >= hd);
        th = (t == 0) ? "R8" : (hd == 0) ? "R9" : "R7";
        check(th, int'(ref_hold), eh);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", int'(fast_sel), 0);
    check("R10", int'(ref_hold), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R10", int'(fast_sel), 0);
    check("R10", int'(ref_hold), 0);

    // Sweep modes, direction flags, durations and hold delay.
    for (int md = 0; md < 4; md++)
      for (int dc = 0; dc < 4; dc++)
        for (int dp = 0; dp < 3; dp++)
          for (int hh = 0; hh < 2; hh++) begin
            int dn, up;
            dn = (dp == 0) ? 0 : (dp == 1) ? 4 : 2;
            up = (dp == 0) ? 3 : (dp == 1) ? 0 : 5;
            run_step(md, dc, dn, up, hh * 3, 8, "");
          end

    // R6: second step cuts a running fast interval short.
    run_step(3, 1, 6, 0, 0, 2, "");
    run_step(3, 2, 6, 0, 0, 8, "R6");
    run_step(2, 3, 9, 0, 0, 3, "");
    run_step(2, 0, 9, 0, 0, 6, "R6");

    // R1: fixed fast holds across idle time with no step.
    run_step(0, 0, 0, 0, 0, 1, "");
    repeat (10) @(negedge clk);
    check("R1", int'(fast_sel), 3);

    // R7 then R9: engage hold, then clear delay with no step.
    run_step(1, 0, 0, 0, 2, 6, "");
    repeat (20) @(negedge clk);
    check("R7", int'(ref_hold), 1);
    dly_hold = '0;
    @(negedge clk);
    check("R9", int'(ref_hold), 0);
    repeat (4) @(negedge clk);
    check("R9", int'(ref_hold), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule